// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device-side logic of a small serial EEPROM reached over a three-wire, Microwire-style link. It has a chip select, a serial clock and a serial data input. Its only data output is a serial line, modelled as a value plus an output-enable flag. The serial lines are sampled with a faster system clock. An instruction is recognised on rising edges of the serial clock while chip select is high.

The array holds 2048 bits. A static organisation input decides how it is addressed: 256 bytes, or 128 16-bit words. A 16-bit word with index w occupies byte 2w as its high byte and byte 2w+1 as its low byte.

Every operation that changes the array runs a self-timed program cycle of `TPROG` system clocks. A host can poll ready/busy on the data output during that cycle. A persistent enable latch gates all programming. Reads are never gated by that latch.

Top module: `eeprom3w`

## Requirements
- R1: After reset the output enable is 0, the programming latch is disabled, and every byte of the array reads 0x00.
- R2: An instruction is a start bit of 1, then a 2-bit opcode, then the address MSB first. The opcodes are 10 read, 01 write, 11 erase and 00 extended. For a read, once the last address bit is sampled, DO is enabled and shows a dummy 0. Each following SK rise then presents the next data bit, MSB first.
- R3: With programming enabled, a write places its data at the addressed location once the program cycle has ended. The cycle starts on the SK rise that samples the last data bit.
- R4: While the latch is disabled, write, erase, erase-all and write-all leave the array unchanged and start no program cycle. The extended code 00 in the two top address bits disables the latch; code 11 enables it.
- R5: If CS stays low for at least `TCSMIN` clocks and then rises during a program cycle, DO is enabled. It reads 0 until the cycle ends and 1 afterwards, until CS falls.
- R6: If CS rises only after the program cycle has ended, DO stays disabled.
- R7: Erase (opcode 11) sets the addressed location to all ones.
- R8: Erase-all (extended code 10) sets every byte to 0xFF.
- R9: Write-all (extended code 01, followed by a data field) writes its pattern into every location.
- R10: CS falling before an instruction is complete aborts it, and the array is unchanged.
- R11: Read returns the array contents whether the latch is enabled or disabled.
- R12: With `org_x16`=1 there are 7 address bits and 16 data bits, and word w maps to bytes 2w (high) and 2w+1 (low). With `org_x16`=0 there are 8 address bits and 8 data bits.
- R13: A CS low time shorter than `TCSMIN` clocks before CS rises during a program cycle gives no status on DO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_x16 | input | 1 | Organisation: 1 = 128x16, 0 = 256x8 (static) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is sampled on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (read data or ready/busy) |
| dout_oe | output | 1 | Output enable for dout; 0 models high impedance |

## Verification
Two events can fall on the same system clock edge: the CS rise that requests status, and the last count of the program cycle. A rise on that boundary decides whether DO is driven at all. The bench places the CS rise in three positions: well inside the cycle after a long enough low time, inside the cycle after too short a low time, and after the cycle has ended. It judges each case only by the output enable and the level of DO. A read of the location afterwards confirms that the commit happened independently of the status request.

// File: rtl/eeprom3w.sv
module eeprom3w #(
  parameter int TPROG  = 40,
  parameter int TCSMIN = 4,
  parameter int NBYTE  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_x16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  localparam int AW8 = $clog2(NBYTE);
  localparam int AW16 = AW8 - 1;
  localparam int CW = $clog2(TPROG + 1);
  localparam int LW = $clog2(TCSMIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_RD, S_WAIT} st_t;

  st_t              state;
  logic             sk_q, cs_q;
  logic [1:0]       opc;
  logic [AW8-1:0]   addr, p_addr;
  logic [14:0]      wdat;
  logic [15:0]      p_data;
  logic             p_all;
  logic [4:0]       cnt;
  logic             en_q, stat_en, rd_act;
  logic [16:0]      rd_sr;
  logic [CW-1:0]    busy_cnt;
  logic [LW-1:0]    lowcnt;
  logic [7:0]       mem [NBYTE];

  wire sk_rise = sk & ~sk_q;
  wire cs_rise = cs & ~cs_q;
  wire busy    = busy_cnt != '0;
  wire commit  = busy_cnt == CW'(1);
  wire [AW8-1:0] a_n = {addr[AW8-2:0], di};
  wire [15:0]    d_n = {wdat, di};
  wire [1:0]     ext = org_x16 ? a_n[AW8-2:AW8-3] : a_n[AW8-1:AW8-2];
  wire [4:0]     last_a = org_x16 ? 5'(AW16 - 1) : 5'(AW8 - 1);
  wire [4:0]     last_d = org_x16 ? 5'd15 : 5'd7;
  wire [AW8-1:0] hi_b = {a_n[AW8-2:0], 1'b0};
  wire [AW8-1:0] lo_b = {a_n[AW8-2:0], 1'b1};

  assign dout    = stat_en ? ~busy : rd_sr[16];
  assign dout_oe = stat_en | rd_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sk_q     <= 1'b0;
      cs_q     <= 1'b0;
      opc      <= '0;
      addr     <= '0;
      wdat     <= '0;
      cnt      <= '0;
      en_q     <= 1'b0;
      stat_en  <= 1'b0;
      rd_act   <= 1'b0;
      rd_sr    <= '0;
      busy_cnt <= '0;
      lowcnt   <= '0;
      p_all    <= 1'b0;
      p_addr   <= '0;
      p_data   <= '0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (cs) lowcnt <= '0;
      else if (lowcnt != LW'(TCSMIN)) lowcnt <= lowcnt + 1'b1;
      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (!cs) begin
        state   <= S_IDLE;
        rd_act  <= 1'b0;
        stat_en <= 1'b0;
      end else begin
        if (cs_rise && busy && lowcnt == LW'(TCSMIN)) stat_en <= 1'b1;
        if (sk_rise && !busy) begin
          case (state)
            S_IDLE: if (di) begin
              state   <= S_OPC;
              cnt     <= '0;
              addr    <= '0;
              wdat    <= '0;
              stat_en <= 1'b0;
            end
            S_OPC: begin
              opc <= {opc[0], di};
              if (cnt == 5'd1) begin
                state <= S_ADDR;
                cnt   <= '0;
              end else cnt <= cnt + 1'b1;
            end
            S_ADDR: begin
              addr <= a_n;
              if (cnt == last_a) begin
                cnt <= '0;
                case (opc)
                  2'b10: begin
                    rd_sr  <= org_x16 ? {1'b0, mem[hi_b], mem[lo_b]}
                                      : {1'b0, mem[a_n], 8'h00};
                    rd_act <= 1'b1;
                    state  <= S_RD;
                  end
                  2'b01: state <= S_DATA;
                  2'b11: begin
                    state <= S_WAIT;
                    if (en_q) begin
                      busy_cnt <= CW'(TPROG);
                      p_all    <= 1'b0;
                      p_addr   <= a_n;
                      p_data   <= '1;
                    end
                  end
                  default: begin
                    state <= S_WAIT;
                    case (ext)
                      2'b11: en_q <= 1'b1;
                      2'b00: en_q <= 1'b0;
                      2'b10: if (en_q) begin
                        busy_cnt <= CW'(TPROG);
                        p_all    <= 1'b1;
                        p_data   <= '1;
                      end
                      default: state <= S_DATA;
                    endcase
                  end
                endcase
              end else cnt <= cnt + 1'b1;
            end
            S_DATA: begin
              wdat <= d_n[14:0];
              if (cnt == last_d) begin
                state <= S_WAIT;
                if (en_q) begin
                  busy_cnt <= CW'(TPROG);
                  p_all    <= (opc == 2'b00);
                  p_addr   <= addr;
                  p_data   <= org_x16 ? d_n : {d_n[7:0], d_n[7:0]};
                end
              end else cnt <= cnt + 1'b1;
            end
            S_RD: rd_sr <= {rd_sr[15:0], 1'b0};
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      if (p_all) begin
        for (int i = 0; i < NBYTE; i++)
          mem[i] <= (org_x16 && (i % 2 == 0)) ? p_data[15:8] : p_data[7:0];
      end else if (org_x16) begin
        mem[{p_addr[AW8-2:0], 1'b0}] <= p_data[15:8];
        mem[{p_addr[AW8-2:0], 1'b1}] <= p_data[7:0];
      end else begin
        mem[p_addr] <= p_data[7:0];
      end
    end
  end
endmodule

// File: rtl/eeprom3w_chk.sv
module eeprom3w_chk #(
  parameter int TPROG = 40,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          dout_oe,
  input logic          busy,
  input logic          en_q,
  input logic          stat_en,
  input logic          rd_act,
  input logic [CW-1:0] busy_cnt
);
  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout_oe);

  // R4
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en_q);

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(en_q));

  // R6
  stat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_en) |-> busy);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> !busy);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(TPROG));
endmodule

bind eeprom3w eeprom3w_chk #(.TPROG(TPROG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout_oe(dout_oe), .busy(busy),
  .en_q(en_q), .stat_en(stat_en), .rd_act(rd_act), .busy_cnt(busy_cnt)
);

// File: tb/sim_eeprom3w.sv
module sim_eeprom3w;
  localparam int CLK_P  = 10;
  localparam int TPROG  = 40;
  localparam int TCSMIN = 4;

  logic clk = 0, rst_n = 0, org_x16 = 0, cs = 0, sk = 0, di = 0;
  logic dout, dout_oe;
  int total = 0, fails = 0;

  eeprom3w #(.TPROG(TPROG), .TCSMIN(TCSMIN)) u0 (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe));

  always #(CLK_P/2) clk = ~clk;

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    di = b; wclk(2); sk = 1; wclk(2); sk = 0; wclk(2);
  endtask

  task automatic send(logic [15:0] v, int n);
    for (int k = n - 1; k >= 0; k--) bit_out(v[k]);
  endtask

  task automatic cmd(logic [1:0] op, logic [15:0] a, int ab, logic [15:0] d, int db);
    cs = 1; wclk(2);
    bit_out(1); send({14'h0, op}, 2); send(a, ab);
    if (db > 0) send(d, db);
  endtask

  task automatic wait_done;
    cs = 0; wclk(TPROG + 5);
  endtask

  task automatic rd(string req, logic [15:0] a, int ab, int db, logic [15:0] exp);
    logic [15:0] v = 0;
    cmd(2'b10, a, ab, 0, 0);
    check({req, " dummy"}, {14'h0, dout_oe, dout}, 16'h2);
    for (int k = 0; k < db; k++) begin
      bit_out(0);
      v = {v[14:0], dout};
    end
    cs = 0; wclk(2);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R1 oe", {15'h0, dout_oe}, 0);
    rd("R1 R11 read zero", 8'h05, 8, 8, 16'h00);
  endtask

  task automatic t_disabled;
    cmd(2'b01, 8'h05, 8, 16'hA5, 8);
    cs = 0; wclk(TCSMIN + 2); cs = 1; wclk(2);
    check("R4 no busy", {15'h0, dout_oe}, 0);
    wait_done;
    rd("R4 unchanged", 8'h05, 8, 8, 16'h00);
  endtask

  task automatic t_status;
    cmd(2'b00, 8'hC0, 8, 0, 0); cs = 0; wclk(2);
    cmd(2'b01, 8'h3C, 8, 16'h96, 8);
    cs = 0; wclk(TCSMIN + 2); cs = 1; wclk(2);
    check("R5 busy", {14'h0, dout_oe, dout}, 16'h2);
    wclk(TPROG);
    check("R5 ready", {14'h0, dout_oe, dout}, 16'h3);
    cs = 0; wclk(2);
    rd("R2 R3 write read", 8'h3C, 8, 8, 16'h96);
  endtask

  task automatic t_late;
    cmd(2'b01, 8'h10, 8, 16'h5A, 8);
    cs = 0; wclk(TPROG + 5); cs = 1; wclk(2);
    check("R6 late cs", {15'h0, dout_oe}, 0);
    cs = 0; wclk(2);
    rd("R6 data", 8'h10, 8, 8, 16'h5A);
  endtask

  task automatic t_short;
    cmd(2'b01, 8'h11, 8, 16'hC3, 8);
    cs = 0; wclk(1); cs = 1; wclk(2);
    check("R13 short low", {15'h0, dout_oe}, 0);
    wait_done;
    rd("R13 data", 8'h11, 8, 8, 16'hC3);
  endtask

  task automatic t_erase;
    cmd(2'b11, 8'h3C, 8, 0, 0); wait_done;
    rd("R7 erase", 8'h3C, 8, 8, 16'hFF);
  endtask

  task automatic t_abort;
    cs = 1; wclk(2);
    bit_out(1); send(16'h1, 2); send(16'h3C, 8); send(16'h0, 4);
    wait_done;
    rd("R10 abort", 8'h3C, 8, 8, 16'hFF);
  endtask

  task automatic t_wral;
    cmd(2'b00, 8'h40, 8, 16'h6B, 8); wait_done;
    rd("R9 wral lo", 8'h00, 8, 8, 16'h6B);
    rd("R9 wral mid", 8'h3C, 8, 8, 16'h6B);
    rd("R9 wral hi", 8'hFF, 8, 8, 16'h6B);
  endtask

  task automatic t_eral;
    cmd(2'b00, 8'h80, 8, 0, 0); wait_done;
    rd("R8 eral lo", 8'h00, 8, 8, 16'hFF);
    rd("R8 eral hi", 8'hFF, 8, 8, 16'hFF);
  endtask

  task automatic t_x16;
    org_x16 = 1; wclk(2);
    cmd(2'b01, 7'h05, 7, 16'h1234, 16); wait_done;
    rd("R12 word", 7'h05, 7, 16, 16'h1234);
    org_x16 = 0; wclk(2);
    rd("R12 high byte", 8'h0A, 8, 8, 16'h12);
    rd("R12 low byte", 8'h0B, 8, 8, 16'h34);
  endtask

  task automatic t_ewds;
    cmd(2'b00, 8'h00, 8, 0, 0); cs = 0; wclk(2);
    cmd(2'b01, 8'h0A, 8, 16'h55, 8); wait_done;
    rd("R4 R11 disabled read", 8'h0A, 8, 8, 16'h12);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary;
  end

  initial begin
    wclk(4); rst_n = 1; wclk(2);
    t_reset; t_disabled; t_status; t_late; t_short; t_erase;
    t_abort; t_wral; t_eral; t_x16; t_ewds;
    summary;
  end
endmodule